// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog that counts ticks of its clock once software switches it on. It has two separate thresholds. When the count reaches the first one, a level interrupt warns software that it is late. When the count reaches the second one, a single-cycle reset request goes to the chip's reset controller. Software keeps the system alive by writing a restart command, which returns the count to zero.

A status flag records that the last reset request came from this watchdog. The flag is cleared only by the power-on reset input. The ordinary reset input, which the reset controller drives after a bite, leaves the flag alone, so boot software can read why the chip restarted. All registers sit on a plain single-cycle bus. Writes take effect at the clock edge where the write enable is high, and reads are combinational from the address.

Top module: `wdg_two_stage`

## Requirements
- R1: After reset, every register reads zero: restart at offset 0x04, control at 0x08, status at 0x0C (zero after power-on reset), warning threshold at 0x10 and reset threshold at 0x14. An address outside the map also reads zero.
- R2: Control bit 0 starts counting and control bit 1 enables the warning interrupt. With bit 0 set, the count rises by one at every clock edge, starting with the first edge after the write that set it.
- R3: A write of 1 in bit 0 to offset 0x04 makes the count zero at that edge. A write there with bit 0 clear has no effect on the count.
- R4: While control bit 0 is 0, the count is held at zero and neither the interrupt nor the reset request is ever asserted, even if bit 1 is set.
- R5: The interrupt is a level output. It is high while counting is on, bit 1 is set, the warning threshold is nonzero and the count is at or above that threshold. It goes low at the edge of a restart or a disable.
- R6: The reset request is high for exactly one cycle, in the cycle where the count first reaches a nonzero reset threshold: N cycles after the enabling or restarting edge when the threshold is N. A reset threshold of zero never requests a reset.
- R7: The count saturates at the reset threshold. Only one reset request is issued until the next restart or re-enable.
- R8: Status bit 0 becomes 1 in the cycle after a reset request. It survives the ordinary reset, ignores bus writes, and clears only on the power-on reset.
- R9: When both thresholds are equal and bit 1 is clear, the reset request fires on time and the interrupt stays low throughout.
- R10: The thresholds are CNT_W bits wide (29 by default), so 0x10000000 is stored and read back exactly. Write data above bit CNT_W-1 is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock; the count advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the control, thresholds and count (leaves status untouched) |
| por_n | input | 1 | Synchronous active-low power-on reset; clears everything, including status |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, acts at the rising clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| bark_irq | output | 1 | Early-warning interrupt, level |
| bite_req | output | 1 | Reset request, one-cycle pulse |

## Verification
Some rules are checked by the embedded properties on every cycle:
- no output fires while counting is off;
- a restart zeroes the count at the next edge;
- a count that has reached the reset threshold does not move;
- the reset request never lasts two cycles;
- the interrupt needs its enable bit;
- the status flag, once set, stays set until power-on reset.

Other behaviour only the bench's scenarios can show:
- the exact cycle of the warning and of the reset request after an enable or a restart;
- that a restart write with bit 0 clear changes nothing;
- that only one request is issued during a long saturated wait;
- the equal-threshold case without the interrupt;
- that status survives an ordinary reset but not a power-on reset;
- full-width threshold readback.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   // byte offsets of the register map
   localparam logic [7:0] OFS_RESTART = 8'h04;
   localparam logic [7:0] OFS_CTRL    = 8'h08;
   localparam logic [7:0] OFS_STATUS  = 8'h0C;
   localparam logic [7:0] OFS_WARN    = 8'h10;
   localparam logic [7:0] OFS_LIMIT   = 8'h14;

   // control register bit positions
   localparam int CTRL_RUN_BIT = 0;
   localparam int CTRL_IRQ_BIT = 1;

   // restart command bit and status bit
   localparam int RESTART_BIT  = 0;
   localparam int STATUS_BIT   = 0;
endpackage

// File: rtl/wdg_regfile.sv
module wdg_regfile #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              bite_evt,
   output logic              run,
   output logic              irq_en,
   output logic              restart,
   output logic [CNT_W-1:0]  warn_thr,
   output logic [CNT_W-1:0]  limit_thr,
   output logic              cause_flag,
   output logic [DATA_W-1:0] rdata
);
   import wdg_pkg::*;

   localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFS_RESTART);
   localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_WARN    = ADDR_W'(OFS_WARN);
   localparam logic [ADDR_W-1:0] A_LIMIT   = ADDR_W'(OFS_LIMIT);

   logic soft_clr;
   assign soft_clr = !rst_n || !por_n;

   // restart is a command, it acts at the write edge
   assign restart = wr && (addr == A_RESTART) && wdata[RESTART_BIT];

   always_ff @(posedge clk) begin
      if (soft_clr) begin
         run       <= 1'b0;
         irq_en    <= 1'b0;
         warn_thr  <= '0;
         limit_thr <= '0;
      end else if (wr) begin
         case (addr)
            A_CTRL: begin
               run    <= wdata[CTRL_RUN_BIT];
               irq_en <= wdata[CTRL_IRQ_BIT];
            end
            A_WARN:  warn_thr  <= wdata[CNT_W-1:0];
            A_LIMIT: limit_thr <= wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   // cause flag only follows the power-on reset
   always_ff @(posedge clk) begin
      if (!por_n)        cause_flag <= 1'b0;
      else if (bite_evt) cause_flag <= 1'b1;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL: begin
            rdata[CTRL_RUN_BIT] = run;
            rdata[CTRL_IRQ_BIT] = irq_en;
         end
         A_STATUS: rdata[STATUS_BIT] = cause_flag;
         A_WARN:   rdata[CNT_W-1:0]  = warn_thr;
         A_LIMIT:  rdata[CNT_W-1:0]  = limit_thr;
         default:  rdata = '0;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   // R8
   cause_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      cause_flag |=> cause_flag);
   // R8
   cause_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      bite_evt |=> cause_flag);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int CNT_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_n,
   input  logic             run,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit_thr,
   output logic [CNT_W-1:0] cnt
);
   logic at_limit;
   assign at_limit = (cnt >= limit_thr);

   always_ff @(posedge clk) begin
      if (!rst_n || !por_n)    cnt <= '0;
      else if (!run || restart) cnt <= '0;
      else if (!at_limit)       cnt <= cnt + 1'b1;
   end

   // R3
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      restart |=> (cnt == '0));
   // R7
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (run && !restart && at_limit) |=> (cnt == $past(cnt)));
   // R4
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      !run |=> (cnt == '0));
endmodule

// File: rtl/wdg_stages.sv
module wdg_stages #(
   parameter int CNT_W    = 29,
   parameter bit HAS_WARN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_n,
   input  logic             run,
   input  logic             irq_en,
   input  logic             restart,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] warn_thr,
   input  logic [CNT_W-1:0] limit_thr,
   output logic             warn,
   output logic             bite
);
   logic bitten;

   generate
      if (HAS_WARN) begin : g_warn
         assign warn = run && irq_en && (warn_thr != '0) && (cnt >= warn_thr);
      end else begin : g_nowarn
         logic unused_warn;
         assign unused_warn = irq_en ^ (^warn_thr);
         assign warn = 1'b0;
      end
   endgenerate

   assign bite = run && (limit_thr != '0) && (cnt >= limit_thr) && !bitten;

   always_ff @(posedge clk) begin
      if (!rst_n || !por_n)     bitten <= 1'b0;
      else if (!run || restart) bitten <= 1'b0;
      else if (bite)            bitten <= 1'b1;
   end

   // R6
   bite_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (bite && !restart) |=> !bite);
   // R5
   warn_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      warn |-> irq_en);
endmodule

// File: rtl/wdg_two_stage.sv
module wdg_two_stage #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 29,
   parameter bit HAS_WARN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bark_irq,
   output logic              bite_req
);
   initial begin
      assert (CNT_W >= 29 && CNT_W <= DATA_W)
         else $fatal(1, "CNT_W must lie between 29 and DATA_W");
      assert (ADDR_W >= 5)
         else $fatal(1, "ADDR_W too narrow for the register map");
   end

   logic             run, irq_en, restart, cause_flag;
   logic [CNT_W-1:0] warn_thr, limit_thr, cnt;

   wdg_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .por_n(por_n),
      .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
      .bite_evt(bite_req),
      .run(run), .irq_en(irq_en), .restart(restart),
      .warn_thr(warn_thr), .limit_thr(limit_thr),
      .cause_flag(cause_flag), .rdata(bus_rdata)
   );

   wdg_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .por_n(por_n),
      .run(run), .restart(restart), .limit_thr(limit_thr), .cnt(cnt)
   );

   wdg_stages #(.CNT_W(CNT_W), .HAS_WARN(HAS_WARN)) u_stages (
      .clk(clk), .rst_n(rst_n), .por_n(por_n),
      .run(run), .irq_en(irq_en), .restart(restart), .cnt(cnt),
      .warn_thr(warn_thr), .limit_thr(limit_thr),
      .warn(bark_irq), .bite(bite_req)
   );

   // R4
   quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      !run |-> (!bark_irq && !bite_req));
endmodule

// File: tb/wdg_two_stage_tb.sv
module wdg_two_stage_tb;
   localparam int AW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          por_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          bark_irq, bite_req;

   int cyc = 0;
   int wr_cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   int exp_q[$];
   bit done = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdg_two_stage u_dut (
      .clk(clk), .rst_n(rst_n), .por_n(por_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bark_irq(bark_irq), .bite_req(bite_req)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // monitor: every reset request must match the head of the expectation queue
   always @(negedge clk) begin
      if (rst_n && por_n && bite_req && !done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected reset request at cycle", cyc, 0);
         end else begin
            int e;
            e = exp_q.pop_front();
            check(cyc == e, "R6", "reset request cycle", cyc, e);
         end
      end
   end

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1;
      bus_wr = 1'b0;
      wr_cyc = cyc;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic at_cycle(input int c);
      do @(negedge clk); while (cyc < c);
   endtask

   task automatic report();
      done = 1'b1;
      while (exp_q.size() != 0) begin
         int e;
         e = exp_q.pop_front();
         check(1'b0, "R6", "expected reset request never seen, cycle", 0, e);
      end
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      check(1'b0, "R1", "watchdog expired", 0, 1);
      report();
   end

   initial begin
      logic [31:0] rd;
      int c0;
      bit saw;

      repeat (3) @(negedge clk);
      rst_n = 1'b1; por_n = 1'b1;

      // R1 reset values
      bus_read(8'h04, rd); check(rd == 0, "R1", "restart reg", rd, 0);
      bus_read(8'h08, rd); check(rd == 0, "R1", "control reg", rd, 0);
      bus_read(8'h0C, rd); check(rd == 0, "R1", "status reg", rd, 0);
      bus_read(8'h10, rd); check(rd == 0, "R1", "warn threshold", rd, 0);
      bus_read(8'h14, rd); check(rd == 0, "R1", "reset threshold", rd, 0);
      bus_read(8'h20, rd); check(rd == 0, "R1", "unmapped address", rd, 0);

      // R6 zero threshold: counting on, never a request
      bus_write(8'h08, 32'h3);
      c0 = wr_cyc;
      at_cycle(c0 + 20);
      check(bark_irq == 0, "R6", "zero thresholds, interrupt", bark_irq, 0);
      bus_write(8'h08, 32'h0);

      // R2 R5 R6 basic run: warn 5, limit 10
      bus_write(8'h10, 32'd5);
      bus_write(8'h14, 32'd10);
      bus_write(8'h08, 32'h3);
      c0 = wr_cyc;
      exp_q.push_back(c0 + 10);
      at_cycle(c0 + 4);
      check(bark_irq == 0, "R5", "interrupt before threshold", bark_irq, 0);
      at_cycle(c0 + 5);
      check(bark_irq == 1, "R2", "interrupt at threshold", bark_irq, 1);
      at_cycle(c0 + 12);
      bus_read(8'h0C, rd); check(rd == 1, "R8", "status after request", rd, 1);
      bus_read(8'h08, rd); check(rd == 3, "R2", "control readback", rd, 3);
      // R7 saturated: no second request while waiting
      at_cycle(c0 + 40);
      check(bark_irq == 1, "R7", "interrupt held while saturated", bark_irq, 1);

      // R3 restart clears; write with bit 0 clear ignored
      bus_write(8'h04, 32'h1);
      c0 = wr_cyc;
      exp_q.push_back(c0 + 10);
      at_cycle(c0);
      check(bark_irq == 0, "R3", "interrupt after restart", bark_irq, 0);
      bus_write(8'h04, 32'h2);
      at_cycle(c0 + 6);
      check(bark_irq == 1, "R3", "interrupt after ignored restart", bark_irq, 1);
      at_cycle(c0 + 20);

      // R4 disable: no outputs; irq bit alone does nothing
      bus_write(8'h08, 32'h2);
      c0 = wr_cyc;
      saw = 1'b0;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (bark_irq) saw = 1'b1;
      end
      check(saw == 0, "R4", "interrupt while stopped", saw, 0);

      // R9 equal thresholds, interrupt disabled
      bus_write(8'h10, 32'd7);
      bus_write(8'h14, 32'd7);
      bus_write(8'h08, 32'h1);
      c0 = wr_cyc;
      exp_q.push_back(c0 + 7);
      saw = 1'b0;
      for (int k = 0; k < 15; k++) begin
         @(negedge clk);
         if (bark_irq) saw = 1'b1;
      end
      check(saw == 0, "R9", "interrupt with equal thresholds", saw, 0);

      // R6 longer threshold after re-enable
      bus_write(8'h08, 32'h0);
      bus_write(8'h14, 32'd300);
      bus_write(8'h08, 32'h1);
      c0 = wr_cyc;
      exp_q.push_back(c0 + 300);
      at_cycle(c0 + 310);

      // R8 status ignores writes, survives ordinary reset
      bus_write(8'h0C, 32'h0);
      bus_read(8'h0C, rd); check(rd == 1, "R8", "status after write", rd, 1);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      bus_read(8'h0C, rd); check(rd == 1, "R8", "status after ordinary reset", rd, 1);
      bus_read(8'h08, rd); check(rd == 0, "R1", "control after ordinary reset", rd, 0);
      bus_read(8'h14, rd); check(rd == 0, "R1", "limit after ordinary reset", rd, 0);
      @(negedge clk); por_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      bus_read(8'h0C, rd); check(rd == 0, "R8", "status after power-on reset", rd, 0);

      // R10 threshold width
      bus_write(8'h14, 32'h1000_0000);
      bus_read(8'h14, rd); check(rd == 32'h1000_0000, "R10", "large limit", rd, 32'h1000_0000);
      bus_write(8'h10, 32'hFFFF_FFFF);
      bus_read(8'h10, rd); check(rd == 32'h1FFF_FFFF, "R10", "truncated warn", rd, 32'h1FFF_FFFF);

      repeat (5) @(negedge clk);
      report();
   end
endmodule